// File: doc/BRIEF.md
# Fractional Prescaled Baud Generator

This block produces the single-cycle bit-rate enable that drives a serial transmitter and receiver. An integer prescaler divides the system clock by a programmable value. Its enable pulses feed a 17-bit phase accumulator, which adds a programmable step on each enable. The output rate is therefore clk / (scale + 1) × step / 2^17. This allows fine, non-integer bit rates from an arbitrary system clock.

Software programs both parameters with one 32-bit configuration word and a one-cycle write strobe. Every write restarts the prescaler and the accumulator from zero, so the tick phase is fixed relative to the write. The block has no data stream, so it has no valid/ready interface. The strobe and the tick are plain control pins. The tick has no back-pressure: a consumer that is not ready loses that bit period.

Top module: `frac_baud_gen`

## Requirements
- R1: The configuration word carries the 12-bit scale in bits 27:16 and the 16-bit step in bits 15:0. Bits 31:28 have no effect on the output.
- R2: A tick is high for exactly one cycle. It appears in the cycle after a prescaler enable whose addition of step carries out of bit 16 of the accumulator. The accumulator keeps the sum modulo 2^17.
- R3: The prescaler enable occurs once every scale+1 cycles. After a write, the first enable is in the cycle at index scale, counting the cycle after the write edge as index 0.
- R4: Two ticks never occur in consecutive cycles, even with step 0xFFFF and scale 0.
- R5: A step of zero produces no tick.
- R6: A write clears the prescaler count, the accumulator and the tick. The tick sequence then restarts from phase zero, whatever state the block had before.
- R7: Over 2^17 consecutive prescaler enables that start from a write, exactly step ticks occur.
- R8: After reset, scale and step are zero and no tick is produced until a write with a nonzero step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Configuration word holding scale and step |
| cfg_wr | input | 1 | One-cycle strobe that loads cfg_word |
| baud_tick | output | 1 | One-cycle bit-rate enable |

## Verification
The bench sweeps every scale from 0 to 3 against steps of 0, 1, 0x8000, 0xFFFF and an irregular value. It compares each cycle with the arithmetic tick position floor(k·step/2^17). An off-by-one prescaler would shift every tick, and a late or early tick register would offset the whole sequence. Each of these fails the cycle-exact comparison. A rewrite in mid-run targets an accumulator or counter left uncleared, which would move the phase of later ticks. A full 2^17-enable run catches a wrong modulus, which would change the tick count away from step. The sweep also sets the top nibble of some words to show that those bits are ignored.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int unsigned CFG_W_D     = 32;
  localparam int unsigned SCALE_W_D   = 12;
  localparam int unsigned STEP_W_D    = 16;
  localparam int unsigned ACC_W_D     = 17;
  localparam int unsigned SCALE_LSB_D = 16;
  localparam int unsigned STEP_LSB_D  = 0;
endpackage

// File: rtl/fbg_cfg_reg.sv
module fbg_cfg_reg #(
  parameter int unsigned CFG_W     = fbg_pkg::CFG_W_D,
  parameter int unsigned SCALE_W   = fbg_pkg::SCALE_W_D,
  parameter int unsigned STEP_W    = fbg_pkg::STEP_W_D,
  parameter int unsigned SCALE_LSB = fbg_pkg::SCALE_LSB_D,
  parameter int unsigned STEP_LSB  = fbg_pkg::STEP_LSB_D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CFG_W-1:0]   cfg_word_i,
  input  logic               cfg_wr_i,
  output logic [SCALE_W-1:0] scale_o,
  output logic [STEP_W-1:0]  step_o
);
  localparam int unsigned SCALE_MSB = SCALE_LSB + SCALE_W - 1;
  localparam int unsigned STEP_MSB  = STEP_LSB + STEP_W - 1;

  // Bits outside the two fields are accepted and dropped.
  logic unused_ok;
  assign unused_ok = ^cfg_word_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_o <= '0;
      step_o  <= '0;
    end else if (cfg_wr_i) begin
      scale_o <= cfg_word_i[SCALE_MSB:SCALE_LSB];
      step_o  <= cfg_word_i[STEP_MSB:STEP_LSB];
    end
  end
endmodule

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
  parameter int unsigned SCALE_W = fbg_pkg::SCALE_W_D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               en_o
);
  logic [SCALE_W-1:0] cnt_q;
  logic               hit;

  assign hit  = (cnt_q == scale_i);
  assign en_o = hit && !clr_i;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_q <= '0;
    end else if (hit) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + SCALE_W'(1);
    end
  end
endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc #(
  parameter int unsigned STEP_W = fbg_pkg::STEP_W_D,
  parameter int unsigned ACC_W  = fbg_pkg::ACC_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              tick_o
);
  localparam int unsigned SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, acc_q} + SUM_W'(step_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (en_i) begin
      acc_q  <= sum[ACC_W-1:0];
      tick_o <= sum[ACC_W];
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int unsigned CFG_W     = fbg_pkg::CFG_W_D,
  parameter int unsigned SCALE_W   = fbg_pkg::SCALE_W_D,
  parameter int unsigned STEP_W    = fbg_pkg::STEP_W_D,
  parameter int unsigned ACC_W     = fbg_pkg::ACC_W_D,
  parameter int unsigned SCALE_LSB = fbg_pkg::SCALE_LSB_D,
  parameter int unsigned STEP_LSB  = fbg_pkg::STEP_LSB_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             cfg_wr,
  output logic             baud_tick
);
  logic [SCALE_W-1:0] scale_q;
  logic [STEP_W-1:0]  step_q;
  logic               presc_en;

  fbg_cfg_reg #(
    .CFG_W(CFG_W), .SCALE_W(SCALE_W), .STEP_W(STEP_W),
    .SCALE_LSB(SCALE_LSB), .STEP_LSB(STEP_LSB)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_word_i(cfg_word), .cfg_wr_i(cfg_wr),
    .scale_o(scale_q), .step_o(step_q)
  );

  fbg_prescaler #(.SCALE_W(SCALE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr_i(cfg_wr), .scale_i(scale_q), .en_o(presc_en)
  );

  fbg_phase_acc #(.STEP_W(STEP_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(cfg_wr), .en_i(presc_en),
    .step_i(step_q), .tick_o(baud_tick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int unsigned SCALE_W = fbg_pkg::SCALE_W_D,
  parameter int unsigned STEP_W  = fbg_pkg::STEP_W_D
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_wr,
  input logic               baud_tick,
  input logic               presc_en,
  input logic [SCALE_W-1:0] scale_q,
  input logic [STEP_W-1:0]  step_q
);
  p_tick_after_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(presc_en));

  p_prescale_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_en && !cfg_wr && scale_q != '0) |=> !presc_en);

  p_no_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  p_zero_step_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == '0 && $stable(step_q)) |=> !baud_tick);

  p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !baud_tick);
endmodule

bind frac_baud_gen fbg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .baud_tick(baud_tick),
  .presc_en(presc_en), .scale_q(scale_q), .step_q(step_q)
);

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        cfg_wr = 1'b0;
  logic        baud_tick;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_wr(cfg_wr), .baud_tick(baud_tick)
  );

  // Expected tick at cycle index c after a write (index 0 = cycle after write edge).
  function automatic bit exp_tick(longint c, longint s, longint st);
    longint k;
    if (c < s + 1 || (c % (s + 1)) != 0) return 1'b0;
    k = c / (s + 1);
    return ((k * st) >> 17) != (((k - 1) * st) >> 17);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] w);
    @(negedge clk);
    cfg_word = w;
    cfg_wr   = 1'b1;
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  // Write w, then compare cycle by cycle for n cycles.
  task automatic run_cfg(logic [31:0] w, int n, string req, output longint ticks,
                         output int first_bad, output bit back2back);
    longint s  = longint'(w[27:16]);
    longint st = longint'(w[15:0]);
    bit prev = 1'b0;
    int mism = 0;
    ticks = 0;
    first_bad = -1;
    back2back = 1'b0;
    wr(w);
    for (int c = 0; c < n; c++) begin
      bit e = exp_tick(c, s, st);
      if (baud_tick !== e) begin
        mism++;
        if (first_bad < 0) first_bad = c;
      end
      if (baud_tick === 1'b1) begin
        ticks++;
        if (prev) back2back = 1'b1;
      end
      prev = (baud_tick === 1'b1);
      @(negedge clk);
    end
    check(mism == 0, req, longint'(first_bad), -1);
  endtask

  initial begin
    #(20ns * 198000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint ticks;
    int fb;
    bit b2b;
    logic [31:0] steps [5] = '{32'h0, 32'h1, 32'h8000, 32'hFFFF, 32'h1D6B};

    repeat (4) @(negedge clk);
    check(baud_tick === 1'b0, "R8 in reset", longint'(baud_tick), 0);
    rst_n = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (baud_tick === 1'b1) seen++;
      end
      check(seen == 0, "R8 idle after reset", seen, 0);
    end

    // Sweep: R1 R2 R3 with scales 0..3 and a step set; odd scales carry junk in 31:28.
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < 5; j++) begin
        logic [31:0] w = {((s % 2) == 1) ? 4'hA : 4'h0, 12'(s), steps[j][15:0]};
        run_cfg(w, 1500, "R1/R2/R3 sweep", ticks, fb, b2b);
        if (steps[j] == 32'h0) check(ticks == 0, "R5 zero step", ticks, 0);
        if (steps[j] == 32'hFFFF) check(!b2b, "R4 no consecutive ticks", longint'(b2b), 0);
      end
    end

    // R6: run with state mid-phase, then rewrite; phase must restart from zero.
    wr({4'h0, 12'd2, 16'h9000});
    repeat (7) @(negedge clk);
    run_cfg({4'h0, 12'd2, 16'h9000}, 600, "R6 rewrite restarts phase", ticks, fb, b2b);
    wr({4'h0, 12'd1, 16'hC001});
    repeat (5) @(negedge clk);
    run_cfg({4'h0, 12'd3, 16'h4321}, 600, "R6 rewrite new value", ticks, fb, b2b);

    // R7: 2^17 enables at scale 0; index 131072 holds the last tick.
    run_cfg({4'h0, 12'd0, 16'h1235}, 131073, "R7 full window", ticks, fb, b2b);
    check(ticks == 64'h1235, "R7 tick count equals step", ticks, 64'h1235);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule